// File: doc/BRIEF.md
# Polled Interrupt Event Controller

This block gathers level-sensitive hardware interrupt lines, software-raised pending bits and inter-processor interrupts for a small cluster of cores. Each source carries a mask bit, a software-pending bit and a routing register. The routing register holds one bit per core. Each core asks for work by reading a shared event address. The reply names the kind of event and its index. The read also masks what it reports, so the same event is not handed out twice. Software then services the source and unmasks it, and it keeps reading until the reply says there is nothing left.

All access goes through a 32-bit register port that uses a valid/ready request channel and a valid/ready response channel. Each request carries the identity of the core that issued it. A request is accepted in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while an earlier response is still waiting for `rsp_ready`. Every accepted request, read or write, gives exactly one response in the next cycle. That response holds its data unchanged until it is taken. One output per core shows that the core has an event waiting.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset every source mask bit is 1, every software-pending bit is 0, every routing register is 0, no IPI is pending or masked, no response is pending and every `core_irq` bit is 0.
- R2: A read of address 0x0004 returns the source count NUM_SRC in bits [15:0] and zero above. A read of 0x2000 returns the requesting core's `req_core` value.
- R3: Source n has software-pending bit (n mod 32) in the word at offset 4*(n/32) from 0x4000 (set) and 0x4080 (clear), and mask bit (n mod 32) at the same offset from 0x4100 (set) and 0x4180 (clear). A write changes only the bits written as 1. A read of either address of a pair returns the current bits.
- R4: The routing register of source n is at 0x3000 + 4n. Its bit c sends the source to core c, and it reads back as written in bits [NUM_CORES-1:0].
- R5: Source n is pending when its line or its software-pending bit is 1. Core c can be given the source only if it is pending, its mask bit is 0 and bit c of its routing register is 1.
- R6: A read of 0x2004 returns the kind in bits [31:16] and data in bits [15:0]. Kind 0 means nothing is pending (data 0). Kind 1 is a hardware source, with its index as data. Kind 4 is an IPI, with data 1.
- R7: A pending, unmasked IPI for the core comes before any hardware source. Among hardware sources, the lowest index wins.
- R8: A read of 0x2004 that returns kind 1 for source n sets the mask bit of n.
- R9: A write to 0x2008 marks an IPI pending for every core whose bit is 1. A write with bit 0 set to 0x200C clears the requesting core's pending IPI. A read of 0x2004 that returns kind 4 masks IPIs for that core until it writes bit 0 to 0x2028.
- R10: `core_irq[c]` is high exactly when a read of 0x2004 by core c would return a nonzero kind.
- R11: A response appears in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_rdata` holds. Read data shows the state before the access's own side effect.
- R12: Writes to any address other than the write-one and routing registers change nothing. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_SRC | Level-sensitive hardware interrupt lines |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| req_core | input | CID_W | Identity of the requesting core |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| core_irq | output | NUM_CORES | Per-core event-waiting flag |

## Verification
The event read has to capture its reply and mask the source it names at the same clock edge, while hardware lines change underneath it. The bench raises a lower-numbered line during the same cycle that an event read is accepted, with a higher source already waiting. It then checks that the reply names the newly raised lower source and that only that source becomes masked. The source that was already waiting must be reported by the following read. A second overlap is a response held by back-pressure while the line state changes. The held data must stay what was captured at acceptance.

// File: rtl/iec_pkg.sv
`timescale 1ns/1ps
package iec_pkg;
  localparam logic [15:0] EV_NONE   = 16'd0;
  localparam logic [15:0] EV_HW     = 16'd1;
  localparam logic [15:0] EV_IPI    = 16'd4;
  localparam logic [15:0] IPI_OTHER = 16'd1;

  localparam logic [15:0] A_INFO    = 16'h0004;
  localparam logic [15:0] A_SELF    = 16'h2000;
  localparam logic [15:0] A_EVENT   = 16'h2004;
  localparam logic [15:0] A_IPI_TX  = 16'h2008;
  localparam logic [15:0] A_IPI_ACK = 16'h200C;
  localparam logic [15:0] A_IPI_ON  = 16'h2028;
  localparam logic [15:0] A_ROUTE   = 16'h3000;
  localparam logic [15:0] A_SW_SET  = 16'h4000;
  localparam logic [15:0] A_SW_CLR  = 16'h4080;
  localparam logic [15:0] A_MK_SET  = 16'h4100;
  localparam logic [15:0] A_MK_CLR  = 16'h4180;

  typedef struct packed {
    logic [15:0] kind;
    logic [15:0] data;
  } event_t;
endpackage

// File: rtl/iec_src_bank.sv
`timescale 1ns/1ps
module iec_src_bank #(
  parameter int NUM_CORES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sw_set_we,
  input  logic                        sw_clr_we,
  input  logic                        mk_set_we,
  input  logic                        mk_clr_we,
  input  logic [31:0]                 wbits,
  input  logic [31:0]                 take,
  input  logic [31:0]                 route_we,
  input  logic [NUM_CORES-1:0]        route_wval,
  output logic [31:0]                 sw_q,
  output logic [31:0]                 mask_q,
  output logic [31:0][NUM_CORES-1:0]  route_q
);
  logic [31:0] sw_set_bits, sw_clr_bits, mk_set_bits, mk_clr_bits;

  assign sw_set_bits = sw_set_we ? wbits : '0;
  assign sw_clr_bits = sw_clr_we ? wbits : '0;
  assign mk_set_bits = mk_set_we ? wbits : '0;
  assign mk_clr_bits = mk_clr_we ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q   <= '0;
      mask_q <= '1;
    end else begin
      sw_q   <= (sw_q | sw_set_bits) & ~sw_clr_bits;
      mask_q <= ((mask_q | mk_set_bits) & ~mk_clr_bits) | take;
    end
  end

  for (genvar i = 0; i < 32; i++) begin : g_route
    always_ff @(posedge clk) begin
      if (!rst_n)           route_q[i] <= '0;
      else if (route_we[i]) route_q[i] <= route_wval;
    end
  end
endmodule

// File: rtl/iec_pick.sv
`timescale 1ns/1ps
module iec_pick
  import iec_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0] live,
  input  logic [NUM_SRC-1:0] route,
  input  logic               ipi_live,
  output event_t             ev
);
  logic [NUM_SRC-1:0] hit;
  assign hit = live & route;

  always_comb begin
    ev = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit[i]) ev = '{kind: EV_HW, data: 16'(i)};
    end
    if (ipi_live) ev = '{kind: EV_IPI, data: IPI_OTHER};
  end
endmodule

// File: rtl/iec_ipi.sv
`timescale 1ns/1ps
module iec_ipi #(
  parameter int NUM_CORES = 4,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send_we,
  input  logic [NUM_CORES-1:0] send_bits,
  input  logic                 ack_we,
  input  logic                 unmask_we,
  input  logic                 take_we,
  input  logic [CID_W-1:0]     core,
  output logic [NUM_CORES-1:0] pend,
  output logic [NUM_CORES-1:0] msk
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic mine;
    assign mine = (int'(core) == c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[c] <= 1'b0;
        msk[c]  <= 1'b0;
      end else begin
        if (send_we && send_bits[c]) pend[c] <= 1'b1;
        else if (ack_we && mine)     pend[c] <= 1'b0;
        if (take_we && mine)         msk[c]  <= 1'b1;
        else if (unmask_we && mine)  msk[c]  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_event_ctrl.sv
`timescale 1ns/1ps
module irq_event_ctrl
  import iec_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 4,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_lines,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [15:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [CID_W-1:0]     req_core,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [31:0]          rsp_rdata,
  output logic [NUM_CORES-1:0] core_irq
);
  localparam int NUM_BANKS = NUM_SRC / 32;
  localparam int IDX_W     = $clog2(NUM_SRC);

  logic acc, wr, rd;
  assign req_ready = !rsp_valid || rsp_ready;
  assign acc = req_valid && req_ready;
  assign wr  = acc && req_write;
  assign rd  = acc && !req_write;

  // decode of bank and routing windows
  logic        bank_ok, route_hit;
  logic [15:0] route_off;
  logic [IDX_W-1:0] route_idx;
  int          bidx;
  assign bidx      = int'(req_addr[6:2]);
  assign bank_ok   = (req_addr[1:0] == 2'b00) && (bidx < NUM_BANKS);
  assign route_off = req_addr - A_ROUTE;
  assign route_hit = (req_addr >= A_ROUTE) && (route_off < 16'(4 * NUM_SRC)) &&
                     (req_addr[1:0] == 2'b00);
  assign route_idx = route_off[IDX_W+1:2];

  logic hit_sws, hit_swc, hit_mks, hit_mkc;
  assign hit_sws = bank_ok && (req_addr[15:7] == A_SW_SET[15:7]);
  assign hit_swc = bank_ok && (req_addr[15:7] == A_SW_CLR[15:7]);
  assign hit_mks = bank_ok && (req_addr[15:7] == A_MK_SET[15:7]);
  assign hit_mkc = bank_ok && (req_addr[15:7] == A_MK_CLR[15:7]);

  // source state
  logic [NUM_SRC-1:0]                sw_all, mask_all, live, take_src;
  logic [NUM_SRC-1:0][NUM_CORES-1:0] route_all;
  logic [NUM_CORES-1:0]              ipi_pend, ipi_msk;
  event_t                            ev_all [NUM_CORES];
  event_t                            ev_sel;
  logic                              core_ok, rd_event;

  assign live     = (irq_lines | sw_all) & ~mask_all;
  assign core_ok  = int'(req_core) < NUM_CORES;
  assign ev_sel   = core_ok ? ev_all[req_core] : '0;
  assign rd_event = rd && (req_addr == A_EVENT);
  assign take_src = (rd_event && ev_sel.kind == EV_HW) ?
                    (NUM_SRC'(1) << ev_sel.data[IDX_W-1:0]) : '0;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    logic [31:0] rwe;
    assign sel = (bidx == b);
    for (genvar i = 0; i < 32; i++) begin : g_rwe
      assign rwe[i] = wr && route_hit && (int'(route_idx) == b * 32 + i);
    end
    iec_src_bank #(.NUM_CORES(NUM_CORES)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .sw_set_we  (wr && hit_sws && sel),
      .sw_clr_we  (wr && hit_swc && sel),
      .mk_set_we  (wr && hit_mks && sel),
      .mk_clr_we  (wr && hit_mkc && sel),
      .wbits      (req_wdata),
      .take       (take_src[b*32 +: 32]),
      .route_we   (rwe),
      .route_wval (req_wdata[NUM_CORES-1:0]),
      .sw_q       (sw_all[b*32 +: 32]),
      .mask_q     (mask_all[b*32 +: 32]),
      .route_q    (route_all[b*32 +: 32])
    );
  end

  iec_ipi #(.NUM_CORES(NUM_CORES)) u_ipi (
    .clk       (clk),
    .rst_n     (rst_n),
    .send_we   (wr && req_addr == A_IPI_TX),
    .send_bits (req_wdata[NUM_CORES-1:0]),
    .ack_we    (wr && req_addr == A_IPI_ACK && req_wdata[0]),
    .unmask_we (wr && req_addr == A_IPI_ON && req_wdata[0]),
    .take_we   (rd_event && ev_sel.kind == EV_IPI),
    .core      (req_core),
    .pend      (ipi_pend),
    .msk       (ipi_msk)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_pick
    logic [NUM_SRC-1:0] route_c;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
      assign route_c[n] = route_all[n][c];
    end
    iec_pick #(.NUM_SRC(NUM_SRC)) u_pick (
      .live     (live),
      .route    (route_c),
      .ipi_live (ipi_pend[c] && !ipi_msk[c]),
      .ev       (ev_all[c])
    );
    assign core_irq[c] = (ev_all[c].kind != EV_NONE);
  end

  // read data mux
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (req_addr == A_INFO)          rd_val = 32'(NUM_SRC);
    else if (req_addr == A_SELF)     rd_val = 32'(req_core);
    else if (req_addr == A_EVENT)    rd_val = ev_sel;
    else if (route_hit)              rd_val = 32'(route_all[route_idx]);
    else if (hit_sws || hit_swc)     rd_val = sw_all[bidx*32 +: 32];
    else if (hit_mks || hit_mkc)     rd_val = mask_all[bidx*32 +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? 32'd0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iec_chk.sv
`timescale 1ns/1ps
module iec_chk
  import iec_pkg::*;
#(
  parameter int NUM_SRC   = 64,
  parameter int NUM_CORES = 4,
  localparam int CID_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic                 req_write,
  input logic [15:0]          req_addr,
  input logic [31:0]          req_wdata,
  input logic [CID_W-1:0]     req_core,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic [31:0]          rsp_rdata,
  input event_t               ev_sel,
  input logic [NUM_SRC-1:0]   mask_all,
  input logic [NUM_CORES-1:0] ipi_pend
);
  logic acc_c;
  assign acc_c = req_valid && req_ready;

  // R8
  hw_take_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && !req_write && req_addr == A_EVENT && ev_sel.kind == EV_HW)
    |=> mask_all[$past(ev_sel.data[IDX_W-1:0])]);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R7
  ipi_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel.kind == EV_IPI) |-> ipi_pend[req_core]);

  // R9
  ipi_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_write && req_addr == A_IPI_ACK && req_wdata[0])
    |=> !ipi_pend[$past(req_core)]);

  // R3
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_c && req_write && req_addr == A_MK_CLR)
    |=> ((mask_all[31:0] & $past(req_wdata)) == 32'd0));
endmodule

bind irq_event_ctrl iec_chk #(.NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_core(req_core), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .ev_sel(ev_sel), .mask_all(mask_all),
  .ipi_pend(ipi_pend)
);

// File: tb/sim_irq_event_ctrl.sv
`timescale 1ns/1ps
module sim_irq_event_ctrl;
  localparam int NS = 64;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0;
  logic [NS-1:0] irq_lines = '0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [1:0]  req_core = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] core_irq;

  always #2.5 clk = ~clk;

  irq_event_ctrl #(.NUM_SRC(NS), .NUM_CORES(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_core(req_core), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .core_irq(core_irq));

  int n_chk = 0, n_bad = 0;
  logic done = 0;
  logic [NS-1:0] m_mask, m_sw;
  logic [NC-1:0] m_route [NS];
  logic [NC-1:0] m_ipi, m_ipim;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ev(int c);
    if (m_ipi[c] && !m_ipim[c]) return {16'd4, 16'd1};
    for (int n = 0; n < NS; n++)
      if ((irq_lines[n] | m_sw[n]) && !m_mask[n] && m_route[n][c])
        return {16'd1, 16'(n)};
    return 32'd0;
  endfunction

  task automatic xfer(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input int c, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_core = 2'(c);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    q = rsp_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input int c = 0);
    logic [31:0] q;
    xfer(1, a, d, c, q);
  endtask

  task automatic rd_chk(string tag, input logic [15:0] a, input int c,
                        input logic [31:0] exp);
    logic [31:0] q;
    xfer(0, a, 0, c, q);
    chk(tag, q, exp);
  endtask

  task automatic ev_read(string tag, input int c);
    logic [31:0] e, q;
    e = exp_ev(c);
    xfer(0, 16'h2004, 0, c, q);
    chk(tag, q, e);
    if (e[31:16] == 16'd1) m_mask[e[5:0]] = 1'b1;
    if (e[31:16] == 16'd4) m_ipim[c] = 1'b1;
  endtask

  task automatic irq_chk(string tag);
    logic [NC-1:0] e;
    @(negedge clk);
    for (int c = 0; c < NC; c++) e[c] = (exp_ev(c) != 0);
    chk(tag, 32'(core_irq), 32'(e));
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic [31:0] q, held;
    m_mask = '1; m_sw = '0; m_ipi = '0; m_ipim = '0;
    for (int n = 0; n < NS; n++) m_route[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 core_irq", 32'(core_irq), 0);
    for (int b = 0; b < NS / 32; b++) begin
      rd_chk("R1 mask", 16'(16'h4100 + 4 * b), 0, 32'hFFFF_FFFF);
      rd_chk("R1 sw", 16'(16'h4080 + 4 * b), 0, 0);
    end
    for (int n = 0; n < NS; n++) rd_chk("R1 route", 16'(16'h3000 + 4 * n), 0, 0);
    for (int c = 0; c < NC; c++) ev_read("R1 event none", c);

    // R2 info and identity
    rd_chk("R2 info", 16'h0004, 1, NS);
    for (int c = 0; c < NC; c++) rd_chk("R2 self", 16'h2000, c, 32'(c));

    // R3 write-one set/clear sweep on every source
    for (int n = 0; n < NS; n++) begin
      logic [15:0] off;
      off = 16'(4 * (n / 32));
      wr(16'h4000 + off, 32'd1 << (n % 32));
      m_sw[n] = 1;
      rd_chk("R3 sw set", 16'h4080 + off, 0, m_sw[(n/32)*32 +: 32]);
      wr(16'h4180 + off, 32'd1 << (n % 32));
      m_mask[n] = 0;
      rd_chk("R3 mask clr", 16'h4100 + off, 0, m_mask[(n/32)*32 +: 32]);
    end
    wr(16'h4080, 32'hFFFF_FFFF); wr(16'h4084, 32'hFFFF_FFFF); m_sw = '0;
    wr(16'h4100, 32'hFFFF_FFFF); wr(16'h4104, 32'hFFFF_FFFF); m_mask = '1;
    rd_chk("R3 sw clear all", 16'h4004, 0, 0);
    rd_chk("R3 mask set all", 16'h4184, 0, 32'hFFFF_FFFF);

    // R4 routing sweep
    for (int n = 0; n < NS; n++) begin
      m_route[n] = 4'(1 << (n % NC));
      wr(16'(16'h3000 + 4 * n), 32'(m_route[n]) | 32'hF0);
    end
    for (int n = 0; n < NS; n++)
      rd_chk("R4 route", 16'(16'h3000 + 4 * n), 0, 32'(m_route[n]));

    // R5 R6 R8 R10 per-source delivery sweep (line or sw-pending)
    wr(16'h4180, 32'hFFFF_FFFF); wr(16'h4184, 32'hFFFF_FFFF); m_mask = '0;
    for (int n = 0; n < NS; n++) begin
      logic [15:0] off;
      off = 16'(4 * (n / 32));
      if (n % 2 == 0) begin
        @(negedge clk); irq_lines = NS'(1) << n;
      end else begin
        wr(16'h4000 + off, 32'd1 << (n % 32)); m_sw[n] = 1;
      end
      irq_chk("R10 core_irq");
      for (int c = 0; c < NC; c++) ev_read("R6 event sweep", c);
      ev_read("R8 masked after read", n % NC);
      rd_chk("R8 mask bit", 16'h4100 + off, 0, m_mask[(n/32)*32 +: 32]);
      @(negedge clk); irq_lines = '0;
      if (n % 2 == 1) begin wr(16'h4080 + off, 32'd1 << (n % 32)); m_sw[n] = 0; end
      wr(16'h4180 + off, 32'd1 << (n % 32)); m_mask[n] = 0;
    end

    // R5 masked source not delivered
    wr(16'h4104, 32'h1); m_mask[32] = 1;
    @(negedge clk); irq_lines = NS'(1) << 32;
    irq_chk("R5 masked no irq");
    ev_read("R5 masked no event", 0);
    @(negedge clk); irq_lines = '0;
    wr(16'h4184, 32'h1); m_mask[32] = 0;

    // R7 R9 priority: IPI first then ascending hardware index, all on core 0
    for (int n = 0; n < NS; n++) if (n == 5 || n == 9 || n == 40) begin
      m_route[n] = 4'b0001; wr(16'(16'h3000 + 4 * n), 32'h1);
    end
    @(negedge clk); irq_lines = (NS'(1) << 40) | (NS'(1) << 9) | (NS'(1) << 5);
    wr(16'h2008, 32'h1); m_ipi[0] = 1;
    ev_read("R7 ipi first", 0);
    ev_read("R7 lowest 5", 0);
    ev_read("R7 then 9", 0);
    ev_read("R7 then 40", 0);
    ev_read("R7 empty", 0);
    wr(16'h200C, 32'h1); m_ipi[0] = 0;
    wr(16'h2028, 32'h1); m_ipim[0] = 0;
    ev_read("R9 acked ipi gone", 0);
    @(negedge clk); irq_lines = '0;
    wr(16'h4180, 32'hFFFF_FFFF); wr(16'h4184, 32'hFFFF_FFFF); m_mask = '0;

    // R9 IPI bitmask, masking by read, ack and unmask
    wr(16'h2008, 32'b1010); m_ipi = 4'b1010;
    irq_chk("R9 ipi irq");
    ev_read("R9 core1 ipi", 1);
    ev_read("R9 core1 masked", 1);
    irq_chk("R9 irq after take");
    wr(16'h2028, 32'h1, 1); m_ipim[1] = 0;
    ev_read("R9 core1 unmasked again", 1);
    wr(16'h200C, 32'h1, 1); m_ipi[1] = 0;
    wr(16'h2028, 32'h1, 1); m_ipim[1] = 0;
    ev_read("R9 core1 done", 1);
    wr(16'h200C, 32'h1, 3); m_ipi[3] = 0;
    ev_read("R9 core3 acked unread", 3);
    ev_read("R9 core0 none", 0);

    // R11 with R8: line 3 rises in the cycle the read is accepted, 7 waiting
    m_route[3] = 4'b0001; wr(16'h300C, 32'h1);
    m_route[7] = 4'b0001; wr(16'h301C, 32'h1);
    @(negedge clk); irq_lines = NS'(1) << 7;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 16'h2004; req_core = 0;
    irq_lines = (NS'(1) << 7) | (NS'(1) << 3);
    @(posedge clk); @(negedge clk); req_valid = 0;
    chk("R11 same-cycle read picks 3", rsp_rdata, {16'd1, 16'd3});
    m_mask[3] = 1;
    ev_read("R8 7 still pending", 0);
    rd_chk("R8 masks 3 and 7 only", 16'h4100, 0, 32'h88);

    // R11 back-pressure: held response while lines change
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = 16'h0004; req_core = 0;
    @(posedge clk); @(negedge clk);
    req_valid = 0; held = rsp_rdata;
    irq_lines = '0;
    @(negedge clk);
    chk("R11 stall valid", 32'(rsp_valid), 1);
    chk("R11 stall ready", 32'(req_ready), 0);
    chk("R11 stall data", rsp_rdata, held);
    chk("R11 held value", held, NS);
    rsp_ready = 1;
    @(negedge clk);
    chk("R11 drained", 32'(rsp_valid), 0);

    // R12 ignored writes and unmapped reads
    wr(16'h5000, 32'hFFFF_FFFF);
    wr(16'h0004, 32'hFFFF_FFFF);
    wr(16'h2004, 32'hFFFF_FFFF);
    wr(16'h3100, 32'hF);
    rd_chk("R12 unmapped", 16'h5000, 0, 0);
    rd_chk("R12 info kept", 16'h0004, 0, NS);
    rd_chk("R12 mask kept", 16'h4104, 0, m_mask[63:32]);
    rd_chk("R12 sw kept", 16'h4000, 0, 0);
    rd_chk("R12 route out of range", 16'h3100, 0, 0);
    for (int c = 0; c < NC; c++) ev_read("R12 events unchanged", c);

    done = 1;
    summary();
  end
endmodule